// File: doc/BRIEF.md
# Instruction Stop-Address Breakpoint

This block gives a processor's debug port a single hardware breakpoint on instruction fetch. A debugger writes a stop address into one register of the debug-port register space and can read it back. The block holds that value and does nothing else with it on the debug side. On the core side, the value is compared over its full width, with no mask, against the PC of the instruction that is about to issue. A match on a valid issue slot raises a halt request at once, in the same cycle, so the matching instruction never takes effect.

The compare is made on every issue, so a breakpoint inside a loop fires on whichever pass reaches it, including under overlapped pipelined execution and without single-stepping. Instruction addresses are always aligned, so bit 0 of a real PC is zero. Any stored value with bit 0 set, such as all ones, therefore can never match and acts as the "off" setting. After a halt the core stays halted until the debugger sends a resume. The instruction it stopped on is then let through once, and later passes over the same address halt again.

Top module: `dbg_stop_unit`

## Requirements
- R1: After reset the stop register reads back as all ones, `halted` is 0, `dbg_ack` is 0 and no halt is requested while `pc_valid` is low.
- R2: A write request to register index 4'b1011 (`dbg_req`=1, `dbg_we`=1) stores `dbg_wdata`, and a later read request to that index returns the stored value on `dbg_rdata`.
- R3: Each request is answered by `dbg_ack` high for exactly one cycle, starting the cycle after the request is first seen. The requester holds its request signals until it sees the acknowledge. Read data is valid on `dbg_rdata` while `dbg_ack` is high.
- R4: A request to any register index other than 4'b1011 leaves the stop register unchanged, and a read of such an index returns zero.
- R5: `halt_req` is high in the same cycle as a valid issue (`pc_valid`=1) whose `pc` equals the stop register in all bits. A PC that differs in any bit, including bit 63, does not halt.
- R6: An issue slot with `pc_valid` low never raises `halt_req` and never sets `halted`.
- R7: While the stored stop address has bit 0 set (for example all ones), no aligned PC ever causes a halt.
- R8: A match sets `halted` on the next clock edge. `halted` and `halt_req` then stay high until `resume` is high on a clock edge, which clears `halted` on that edge.
- R9: After a resume, the first valid issue passes without a halt even if its PC matches. A later valid issue at the stop address, such as the next pass of a loop, halts again.
- R10: A written stop address takes effect on the clock edge that ends the acknowledge cycle. During the acknowledge cycle the old value is still used for the compare and for read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req | input | 1 | Debug-port request, held until acknowledged |
| dbg_we | input | 1 | 1 for a write, 0 for a read |
| dbg_idx | input | IDX_W | Debug-port register index |
| dbg_wdata | input | XLEN | Write data |
| dbg_rdata | output | XLEN | Read data, valid with `dbg_ack` |
| dbg_ack | output | 1 | One-cycle acknowledge |
| pc | input | XLEN | PC of the instruction about to issue |
| pc_valid | input | 1 | Issue slot carries a real instruction |
| resume | input | 1 | Leave the halted state |
| halt_req | output | 1 | Stop the core before this instruction |
| halted | output | 1 | Core is held at the breakpoint |

## Verification
The bench builds the block with its defaults: a 64-bit address and a 4-bit register index. At this width a PC that differs from the stop address only in bit 63 can be presented, which shows that no upper bits are masked. A loop of aligned PCs is run across the breakpoint several times, with and without resume, against a behavioural model checked every cycle. Writes are timed so that a matching PC arrives during the acknowledge cycle, which exposes the point at which a new value takes effect.

// File: rtl/dbg_stop_unit.sv
module dbg_stop_unit #(
  parameter int XLEN = 64,
  parameter int IDX_W = 4,
  parameter logic [IDX_W-1:0] STOP_IDX = 4'b1011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_req,
  input  logic             dbg_we,
  input  logic [IDX_W-1:0] dbg_idx,
  input  logic [XLEN-1:0]  dbg_wdata,
  output logic [XLEN-1:0]  dbg_rdata,
  output logic             dbg_ack,
  input  logic [XLEN-1:0]  pc,
  input  logic             pc_valid,
  input  logic             resume,
  output logic             halt_req,
  output logic             halted
);

  logic [XLEN-1:0] stop_q;
  logic            skip_q;
  logic            sel;
  logic            hit;

  assign sel      = (dbg_idx == STOP_IDX);
  assign hit      = pc_valid && (pc == stop_q) && !halted && !skip_q;
  assign halt_req = halted | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q    <= '1;
      dbg_ack   <= 1'b0;
      dbg_rdata <= '0;
    end else begin
      dbg_ack <= dbg_req & ~dbg_ack;
      if (dbg_req && !dbg_ack)
        dbg_rdata <= sel ? stop_q : '0;
      if (dbg_req && dbg_ack && dbg_we && sel)
        stop_q <= dbg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted <= 1'b0;
      skip_q <= 1'b0;
    end else if (halted && resume) begin
      halted <= 1'b0;
      skip_q <= 1'b1;
    end else if (hit) begin
      halted <= 1'b1;
    end else if (skip_q && pc_valid) begin
      skip_q <= 1'b0;
    end
  end

  a_r3_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ack |=> !dbg_ack);

  a_r4_other_idx_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && dbg_ack && !sel) |=> $stable(stop_q));

  a_r5_halt_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(pc_valid && pc == stop_q));

  a_r6_no_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_valid && !halted) |=> !halted);

  a_r8_hold_until_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !resume) |=> halted);

  a_r8_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && resume) |=> !halted);

  a_r9_no_rehalt: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> !halt_req);

endmodule

// File: tb/dbg_stop_unit_test.sv
module dbg_stop_unit_test;
  localparam logic [3:0] SI = 4'b1011;

  logic clk = 0, rst_n = 0;
  logic dbg_req = 0, dbg_we = 0, pc_valid = 0, resume = 0;
  logic [3:0] dbg_idx = 0;
  logic [63:0] dbg_wdata = 0, pc = 0;
  logic [63:0] dbg_rdata;
  logic dbg_ack, halt_req, halted;

  int total = 0, bad = 0;

  dbg_stop_unit uut (.*);

  always #10 clk = ~clk;

  // reference model
  logic [63:0] m_stop, m_rd;
  logic m_ack, m_halted, m_skip;
  always @(posedge clk) begin
    logic hit, oack;
    if (!rst_n) begin
      m_stop = '1; m_ack = 0; m_rd = 0; m_halted = 0; m_skip = 0;
    end else begin
      hit = pc_valid && pc == m_stop && !m_halted && !m_skip;
      oack = m_ack;
      if (dbg_req && !oack) m_rd = (dbg_idx == SI) ? m_stop : 64'h0;
      if (dbg_req && oack && dbg_we && dbg_idx == SI) m_stop = dbg_wdata;
      m_ack = dbg_req && !oack;
      if (m_halted && resume) begin m_halted = 0; m_skip = 1; end
      else if (hit) m_halted = 1;
      else if (m_skip && pc_valid) m_skip = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      logic eh;
      eh = m_halted || (pc_valid && pc == m_stop && !m_skip);
      chk(halt_req === eh, "R5/R8 model halt_req", 64'(halt_req), 64'(eh));
      chk(halted === m_halted, "R8 model halted", 64'(halted), 64'(m_halted));
      chk(dbg_ack === m_ack, "R3 model ack", 64'(dbg_ack), 64'(m_ack));
      if (m_ack) chk(dbg_rdata === m_rd, "R2/R4 model rdata", dbg_rdata, m_rd);
    end
  end

  task automatic dmi(input bit we, input logic [3:0] idx, input logic [63:0] d, output logic [63:0] rd);
    @(negedge clk);
    dbg_req = 1; dbg_we = we; dbg_idx = idx; dbg_wdata = d;
    @(negedge clk); #5;
    chk(dbg_ack === 1'b1, "R3 ack follows request", 64'(dbg_ack), 64'd1);
    rd = dbg_rdata;
    @(negedge clk);
    dbg_req = 0; dbg_we = 0;
  endtask

  task automatic issue(input logic [63:0] a, input logic v);
    @(negedge clk);
    pc = a; pc_valid = v;
    #5;
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    chk(halted === 0, "R1 halted after reset", 64'(halted), 0);
    chk(dbg_ack === 0, "R1 ack after reset", 64'(dbg_ack), 0);
    chk(halt_req === 0, "R1 no halt idle", 64'(halt_req), 0);
    dmi(0, SI, 0, r);
    chk(r === '1, "R1 stop reads all ones", r, '1);

    // R4 other index
    dmi(1, 4'd3, 64'h100, r);
    dmi(0, 4'd3, 0, r);
    chk(r === 0, "R4 other idx reads zero", r, 0);
    dmi(0, SI, 0, r);
    chk(r === '1, "R4 stop unchanged", r, '1);

    // R7 disabled
    for (int i = 0; i < 20; i++) begin
      issue(64'(i * 4), 1);
      chk(halt_req === 0, "R7 all ones disables", 64'(halt_req), 0);
    end
    issue(0, 0);
    dmi(1, SI, 64'h101, r);
    issue(64'h100, 1);
    chk(halt_req === 0, "R7 odd stop disables", 64'(halt_req), 0);
    issue(0, 0);

    // R2 write/read
    dmi(1, SI, 64'h40, r);
    dmi(0, SI, 0, r);
    chk(r === 64'h40, "R2 readback", r, 64'h40);

    // R6
    issue(64'h40, 0);
    chk(halt_req === 0, "R6 invalid slot no halt", 64'(halt_req), 0);
    @(negedge clk); #5;
    chk(halted === 0, "R6 not halted", 64'(halted), 0);

    // R5
    issue(64'h8000_0000_0000_0040, 1);
    chk(halt_req === 0, "R5 bit63 differs", 64'(halt_req), 0);
    issue(64'h40, 1);
    chk(halt_req === 1, "R5 match halts same cycle", 64'(halt_req), 1);
    issue(64'h44, 0);
    chk(halted === 1, "R8 halted next edge", 64'(halted), 1);
    repeat (4) begin
      issue(64'h44, 0);
      chk(halted === 1 && halt_req === 1, "R8 stays halted", 64'(halted), 1);
    end

    // R8/R9 resume
    @(negedge clk); resume = 1; pc = 64'h40; pc_valid = 0;
    @(negedge clk); resume = 0; #5;
    chk(halted === 0, "R8 resume clears", 64'(halted), 0);
    issue(64'h40, 1);
    chk(halt_req === 0, "R9 resumed instr passes", 64'(halt_req), 0);
    for (int i = 0; i < 4; i++) begin
      issue(64'h30 + 64'(i * 4), 1);
      chk(halt_req === 0, "R9 loop body no halt", 64'(halt_req), 0);
    end
    issue(64'h40, 1);
    chk(halt_req === 1, "R9 next loop pass halts", 64'(halt_req), 1);
    issue(0, 0);
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0;
    issue(64'h10, 1);

    // R10 timing of write
    @(negedge clk);
    pc_valid = 0;
    dbg_req = 1; dbg_we = 1; dbg_idx = SI; dbg_wdata = 64'h20;
    @(negedge clk);
    pc = 64'h20; pc_valid = 1; #5;
    chk(dbg_ack === 1, "R10 ack cycle", 64'(dbg_ack), 1);
    chk(halt_req === 0, "R10 old value in ack cycle", 64'(halt_req), 0);
    @(negedge clk);
    dbg_req = 0; dbg_we = 0; #5;
    chk(halt_req === 1, "R10 new value after ack", 64'(halt_req), 1);
    issue(0, 0);
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0;
    dmi(0, SI, 0, r);
    chk(r === 64'h20, "R10 stored", r, 64'h20);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule